// File: doc/BRIEF.md
# Lockable SMM Memory Window Decoder

This block guards the fixed 128 KB legacy system-management memory window at addresses A0000h to BFFFFh. It holds one 8-bit control register, reached through a plain configuration read/write port, and a combinational decoder that the register drives. For every memory request that falls inside the window, the decoder looks at the SMM-mode indication and at the code-fetch flag. It then claims the request for local DRAM or hands it to the downstream forwarding port. The window is never relocated. It is only made visible or hidden.

Firmware uses the open control to reach the window outside SMM while it fills in the handler. It then sets the lock. The lock clears the open control and freezes lock, open and global enable until a full reset. The close control lets SMM data references pass downstream, for example to reach a display buffer that shares the window. SMM code fetches still come from DRAM while close is set.

Top module: `smm_window_guard`

## Requirements
- R1: After reset, open, close, lock and global enable are all 0, and a read at offset 9Dh returns 02h.
- R2: In a read at offset 9Dh, bits 2:0 always return 010b and bit 7 always returns 0, whatever was written to those bits. Bits 6, 5, 4 and 3 return open, close, lock and global enable. A read at any other offset returns 00h.
- R3: A write at offset 9Dh takes effect on the clock edge after the write strobe. A write at any other offset changes nothing.
- R4: While global enable (bit 3) is 0, every valid request inside the window is forwarded (route_fwd=1, route_dram=0), whatever open, close and lock hold.
- R5: With global enable set and close clear, a valid SMM-mode request inside the window is routed to DRAM.
- R6: With global enable set, a valid non-SMM request inside the window is routed to DRAM when open=1 and lock=0. Otherwise it is forwarded.
- R7: With global enable and close (bit 5) set, an SMM data reference inside the window is forwarded, and an SMM code fetch inside the window is routed to DRAM.
- R8: Once written to 1, lock (bit 4) stays 1 through any later write and is cleared only by reset.
- R9: A write that sets lock stores open as 0 in the same edge, even if that write also sets open. While lock is 1, writes leave lock, open and global enable unchanged, and close stays writable.
- R10: A request with req_valid low, or with an address outside A0000h to BFFFFh, drives both route outputs to 0. At most one route output is ever high.
- R11: With open and close both set, global enable set and lock clear, SMM data references are forwarded and non-SMM requests inside the window are routed to DRAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high full reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr |
| req_valid | input | 1 | A memory request is present |
| req_addr | input | 32 | Request byte address |
| req_smm | input | 1 | Request is made in SMM mode |
| req_code | input | 1 | Request is a code fetch (0 = data reference) |
| route_dram | output | 1 | Request inside the window is claimed by DRAM |
| route_fwd | output | 1 | Request inside the window is sent downstream |

## Verification
The assertions assume that the configuration inputs and the request inputs are stable around each rising edge, and that reset is held for at least one edge before any check counts. They also assume that the SMM-mode and code flags are meaningful only while req_valid is high. The bench drives every input just after the falling edge and holds it for a full cycle. It raises reset at time zero and again in the middle of the run. It chooses request addresses from the two window edges, from the words just outside the window, and from random points. It also toggles req_valid, so that idle and out-of-window cycles are part of the stimulus.

// File: rtl/smm_pkg.sv
package smm_pkg;

  // Field positions in the control byte. Software decodes these, so they are fixed.
  localparam int BIT_OPEN  = 6;
  localparam int BIT_CLOSE = 5;
  localparam int BIT_LOCK  = 4;
  localparam int BIT_EN    = 3;
  localparam int SEG_LSB   = 0;
  localparam int SEG_W     = 3;
  localparam logic [SEG_W-1:0] SEG_CODE = 3'b010;

  typedef struct packed {
    logic open;
    logic close;
    logic lock;
    logic enable;
  } smm_ctl_t;

  typedef enum logic [1:0] {
    ROUTE_NONE = 2'b00,
    ROUTE_DRAM = 2'b01,
    ROUTE_FWD  = 2'b10
  } route_e;

endpackage

// File: rtl/smm_cfg_reg.sv
module smm_cfg_reg
  import smm_pkg::*;
#(
  parameter int CFG_AW = 8,
  parameter int CFG_DW = 8,
  parameter logic [CFG_AW-1:0] REG_OFFSET = 8'h9D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  output smm_ctl_t          ctl
);

  smm_ctl_t ctl_q;
  logic     hit;
  logic     wr_en;
  logic     unused_wbits;

  assign hit          = (cfg_addr == REG_OFFSET);
  assign wr_en        = cfg_wr && hit;
  assign unused_wbits = ^{cfg_wdata[CFG_DW-1:BIT_OPEN+1], cfg_wdata[SEG_LSB+SEG_W-1:SEG_LSB]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (wr_en) begin
      if (!ctl_q.lock) begin
        ctl_q.enable <= cfg_wdata[BIT_EN];
        ctl_q.lock   <= cfg_wdata[BIT_LOCK];
        // A lock in the same write wins over open.
        ctl_q.open   <= cfg_wdata[BIT_LOCK] ? 1'b0 : cfg_wdata[BIT_OPEN];
      end
      ctl_q.close <= cfg_wdata[BIT_CLOSE];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (hit) begin
      cfg_rdata[BIT_OPEN]                     = ctl_q.open;
      cfg_rdata[BIT_CLOSE]                    = ctl_q.close;
      cfg_rdata[BIT_LOCK]                     = ctl_q.lock;
      cfg_rdata[BIT_EN]                       = ctl_q.enable;
      cfg_rdata[SEG_LSB+SEG_W-1:SEG_LSB]      = SEG_CODE;
    end
  end

  assign ctl = ctl_q;

endmodule

// File: rtl/smm_window_match.sv
module smm_window_match #(
  parameter int ADDR_W   = 32,
  parameter int WIN_LOG2 = 17,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h000A_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  localparam int TAG_W = ADDR_W - WIN_LOG2;
  localparam logic [TAG_W-1:0] BASE_TAG = WIN_BASE[ADDR_W-1:WIN_LOG2];

  logic unused_low;

  assign unused_low = ^addr[WIN_LOG2-1:0];
  assign hit        = (addr[ADDR_W-1:WIN_LOG2] == BASE_TAG);

endmodule

// File: rtl/smm_route.sv
module smm_route
  import smm_pkg::*;
(
  input  logic     valid,
  input  logic     in_window,
  input  logic     smm,
  input  logic     code,
  input  smm_ctl_t ctl,
  output route_e   route
);

  logic smm_claim;
  logic open_claim;

  assign smm_claim  = !ctl.close || code;
  assign open_claim = ctl.open && !ctl.lock;

  always_comb begin
    route = ROUTE_NONE;
    if (valid && in_window) begin
      if (!ctl.enable)
        route = ROUTE_FWD;
      else if (smm)
        route = smm_claim ? ROUTE_DRAM : ROUTE_FWD;
      else
        route = open_claim ? ROUTE_DRAM : ROUTE_FWD;
    end
  end

endmodule

// File: rtl/smm_window_guard.sv
module smm_window_guard
  import smm_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CFG_AW   = 8,
  parameter int CFG_DW   = 8,
  parameter int WIN_LOG2 = 17,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h000A_0000,
  parameter logic [CFG_AW-1:0] REG_OFFSET = 8'h9D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_smm,
  input  logic              req_code,
  output logic              route_dram,
  output logic              route_fwd
);

  smm_ctl_t ctl;
  logic     in_window;
  route_e   route;

  smm_cfg_reg #(
    .CFG_AW    (CFG_AW),
    .CFG_DW    (CFG_DW),
    .REG_OFFSET(REG_OFFSET)
  ) u_reg (
    .clk      (clk),
    .rst      (rst),
    .cfg_wr   (cfg_wr),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .ctl      (ctl)
  );

  smm_window_match #(
    .ADDR_W  (ADDR_W),
    .WIN_LOG2(WIN_LOG2),
    .WIN_BASE(WIN_BASE)
  ) u_match (
    .addr(req_addr),
    .hit (in_window)
  );

  smm_route u_route (
    .valid    (req_valid),
    .in_window(in_window),
    .smm      (req_smm),
    .code     (req_code),
    .ctl      (ctl),
    .route    (route)
  );

  assign route_dram = (route == ROUTE_DRAM);
  assign route_fwd  = (route == ROUTE_FWD);

endmodule

// File: rtl/smm_window_guard_chk.sv
module smm_window_guard_chk
  import smm_pkg::*;
#(
  parameter int CFG_AW = 8,
  parameter int CFG_DW = 8,
  parameter logic [CFG_AW-1:0] REG_OFFSET = 8'h9D
) (
  input logic              clk,
  input logic              rst,
  input smm_ctl_t          ctl,
  input logic              cfg_wr,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [CFG_DW-1:0] cfg_wdata,
  input logic [CFG_DW-1:0] cfg_rdata,
  input logic              req_valid,
  input logic              req_smm,
  input logic              req_code,
  input logic              route_dram,
  input logic              route_fwd
);

  assert_seg_field_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_addr == REG_OFFSET) |-> (cfg_rdata[2:0] == 3'b010 && !cfg_rdata[CFG_DW-1]));

  assert_other_offset_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_addr != REG_OFFSET) |=> $stable(ctl));

  assert_write_enable_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_addr == REG_OFFSET && !ctl.lock) |=> (ctl.enable == $past(cfg_wdata[BIT_EN])));

  assert_disabled_fwd_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !ctl.enable) |-> !route_dram);

  assert_close_data_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ctl.enable && ctl.close && req_smm && !req_code) |-> !route_dram);

  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    ctl.lock |=> ctl.lock);

  assert_lock_open_R9: assert property (@(posedge clk) disable iff (rst)
    ctl.lock |-> !ctl.open);

  assert_lock_freeze_R9: assert property (@(posedge clk) disable iff (rst)
    ctl.lock |=> $stable(ctl.enable));

  assert_lock_write_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_addr == REG_OFFSET && cfg_wdata[BIT_LOCK] && !ctl.lock) |=> (ctl.lock && !ctl.open));

  assert_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({route_dram, route_fwd}));

  assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> (!route_dram && !route_fwd));

endmodule

bind smm_window_guard smm_window_guard_chk #(
  .CFG_AW    (CFG_AW),
  .CFG_DW    (CFG_DW),
  .REG_OFFSET(REG_OFFSET)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ctl       (ctl),
  .cfg_wr    (cfg_wr),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .req_valid (req_valid),
  .req_smm   (req_smm),
  .req_code  (req_code),
  .route_dram(route_dram),
  .route_fwd (route_fwd)
);

// File: tb/test_smm_window_guard.sv
`timescale 1ns/1ps
module test_smm_window_guard;

  localparam logic [7:0] OFF = 8'h9D;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = OFF;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = 32'h0;
  logic        req_smm = 1'b0;
  logic        req_code = 1'b0;
  logic        route_dram;
  logic        route_fwd;

  always #10 clk = ~clk;

  smm_window_guard i_smm_window_guard (
    .clk(clk), .rst(rst),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_smm(req_smm), .req_code(req_code),
    .route_dram(route_dram), .route_fwd(route_fwd)
  );

  // Behavioural reference state
  bit m_open, m_close, m_lock, m_en;
  bit started = 0;
  bit done = 0;
  int checks = 0;
  int bad = 0;
  int cycles = 0;
  string cur_tag = "R1";

  always @(posedge clk) begin
    cycles <= cycles + 1;
    started = 1;
    if (rst) begin
      m_open = 0; m_close = 0; m_lock = 0; m_en = 0;
    end else if (cfg_wr && cfg_addr == OFF) begin
      if (!m_lock) begin
        m_en   = cfg_wdata[3];
        m_lock = cfg_wdata[4];
        m_open = cfg_wdata[4] ? 1'b0 : cfg_wdata[6];
      end
      m_close = cfg_wdata[5];
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rdata();
    if (cfg_addr != OFF) return 8'h00;
    return {1'b0, m_open, m_close, m_lock, m_en, 3'b010};
  endfunction

  function automatic logic [7:0] exp_route();
    bit inwin;
    bit claim;
    inwin = (req_addr >= 32'h000A_0000) && (req_addr <= 32'h000B_FFFF);
    if (!(req_valid && inwin)) return 8'h00;
    claim = m_en && (req_smm ? (!m_close || req_code) : (m_open && !m_lock));
    return claim ? 8'h01 : 8'h02;
  endfunction

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      check(cur_tag, cfg_rdata, exp_rdata());
      check(cur_tag, {6'b0, route_fwd, route_dram}, exp_route());
    end
  end

  function automatic logic [31:0] pick_addr(bit inside_only);
    int s;
    s = $urandom_range(0, 5);
    if (inside_only) begin
      case (s % 3)
        0: return 32'h000A_0000;
        1: return 32'h000B_FFFF;
        default: return 32'h000A_0000 + ($urandom & 32'h1_FFFF);
      endcase
    end
    case (s)
      0: return 32'h0009_FFFF;
      1: return 32'h000C_0000;
      2: return 32'h000A_0000;
      3: return 32'h000B_FFFF;
      4: return 32'h010A_0000;
      default: return $urandom;
    endcase
  endfunction

  task automatic reqs(int n, bit inside_only);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      req_valid = ($urandom_range(0, 7) != 0);
      req_addr  = pick_addr(inside_only);
      req_smm   = $urandom_range(0, 1);
      req_code  = $urandom_range(0, 1);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); #1;
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); #1;
    cfg_wr = 1'b0; cfg_addr = OFF;
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst = 1'b1;
    @(negedge clk); @(negedge clk); #1;
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    cur_tag = "R1";
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    reqs(8, 1);

    cur_tag = "R4";
    wr(OFF, 8'h60); reqs(30, 1);
    wr(OFF, 8'h70); reqs(20, 1);

    cur_tag = "R8";   // lock written while disabled: sticky
    wr(OFF, 8'h08); reqs(5, 1);
    do_reset();

    cur_tag = "R2";
    wr(OFF, 8'h85); reqs(5, 1);
    cfg_addr = 8'h9C; reqs(3, 0);
    cfg_addr = OFF;

    cur_tag = "R3";
    wr(8'h9C, 8'h48); reqs(5, 1);
    wr(8'h1D, 8'h68); reqs(5, 1);

    cur_tag = "R5";
    wr(OFF, 8'h08); reqs(40, 1);

    cur_tag = "R6";
    wr(OFF, 8'h48); reqs(40, 1);

    cur_tag = "R7";
    wr(OFF, 8'h28); reqs(40, 1);

    cur_tag = "R11";
    wr(OFF, 8'h68); reqs(40, 1);

    cur_tag = "R10";
    reqs(40, 0);

    cur_tag = "R9";
    wr(OFF, 8'h58); reqs(20, 1);
    wr(OFF, 8'h40); reqs(10, 1);
    wr(OFF, 8'h20); reqs(20, 1);
    wr(OFF, 8'h00); reqs(10, 1);

    cur_tag = "R8";
    wr(OFF, 8'h08); reqs(10, 1);
    do_reset();
    reqs(10, 1);
    wr(OFF, 8'h48); reqs(20, 1);

    @(negedge clk);
    finish_run();
  end

  always @(posedge clk) begin
    if (cycles > 20000 && !done) begin
      checks++;
      bad++;
      $display("FAIL watchdog actual=%0d expected<=20000 cycles", cycles);
      finish_run();
    end
  end

endmodule